// File: doc/BRIEF.md
# Two-Entry Branch Target Group Cache

This block sits next to a branch-capable core and remembers where recent taken branches went together with the instructions found there. On every taken branch the update port delivers the target address and the group of three instructions that starts at that address. The store keeps that pair in one of two slots, so that the next time the same target is requested the core can carry on straight away from the stored group instead of waiting for a fetch.

The two slots are ranked by recency. A taken branch that hits the newer slot leaves everything alone. A hit on the older slot swaps the two ranks. A miss replaces the older slot and makes the new entry the newer one. The lookup port is purely combinational: it compares a requested address against both valid slots and returns a hit flag, the stored group and the rank of the slot that matched.

Top module: `branch_group_cache`

## Requirements
- R1: After reset is asserted (rst_n low) both slots are invalid, so every lookup misses until a taken branch is recorded.
- R2: A taken-branch update whose address matches no valid slot stores the address and group; from the next cycle a lookup of that address hits with the stored group and rank 0 (newer).
- R3: A slot that is still empty is filled before any valid slot is replaced, so two updates with distinct addresses after reset both remain present, the first at rank 1 (older) and the second at rank 0.
- R4: An update matching the rank-0 slot changes nothing: the ranks stay the same and the stored group is kept even when the update carries a different group.
- R5: An update matching the rank-1 slot swaps the ranks of the two slots without changing their address or group contents.
- R6: An update that misses while both slots are valid overwrites the rank-1 slot; the new entry becomes rank 0, the former rank-0 entry becomes rank 1, and the replaced address then misses.
- R7: Lookup is combinational; when an update and a lookup happen in the same cycle the lookup reflects the contents before the update, and the update is visible only after the next rising clock edge. Without an update the contents do not change.
- R8: On a miss, lk_hit is 0, lk_group is all zeros and lk_rank is 0.
- R9: The group is packed with instruction k (k = 0, 1, 2, counted from the target address) in bits [k*IW +: IW], and lookup returns it in that same packing.

Top module port list below uses AW = 12, IW = 24 and a group of 3, so the group is 72 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_valid | input | 1 | A branch was taken this cycle; record it |
| upd_addr | input | AW | Target address of the taken branch |
| upd_group | input | GROUP*IW | Instructions starting at the target address |
| lk_addr | input | AW | Address to look up |
| lk_hit | output | 1 | A valid slot holds lk_addr |
| lk_group | output | GROUP*IW | Group of the matching slot, zero on a miss |
| lk_rank | output | 1 | 0 when the newer slot matched, 1 when the older slot matched |

## Verification
The hardest situation to reach from the ports is a taken branch that hits the older slot in the same cycle the lookup port reads it, because both slots must first be filled in a particular order and then the swap must land on exactly the probed cycle. The stimulus fills two targets, reorders them with deliberate hits on each rank, and then drives an update and a lookup of the same older address together, expecting rank 1 in that cycle and rank 0 one cycle later. A long deterministic sequence over only three addresses then forces repeated swaps, no-change hits and replacements, each compared against a ranked list model.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int unsigned NUM_SLOTS = 2;
  typedef enum logic {
    RANK_NEW = 1'b0,
    RANK_OLD = 1'b1
  } rank_e;
endpackage

// File: rtl/bgc_slot.sv
module bgc_slot #(
  parameter int unsigned AW = 12,
  parameter int unsigned GW = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [GW-1:0] wr_group,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [GW-1:0] group_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [GW-1:0] group_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      group_q <= '0;
    end else if (we) begin
      valid_q <= 1'b1;
      addr_q  <= wr_addr;
      group_q <= wr_group;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign group_o = group_q;
endmodule

// File: rtl/bgc_match.sv
module bgc_match #(
  parameter int unsigned AW = 12,
  parameter int unsigned NS = 2
) (
  input  logic [NS-1:0]         slot_v,
  input  logic [NS-1:0][AW-1:0] slot_a,
  input  logic [AW-1:0]         addr,
  output logic [NS-1:0]         hit_vec
);
  for (genvar i = 0; i < NS; i++) begin : g_cmp
    assign hit_vec[i] = slot_v[i] && (slot_a[i] == addr);
  end
endmodule

// File: rtl/bgc_recency.sv
module bgc_recency (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_valid,
  input  logic [1:0] upd_hit,
  input  logic [1:0] slot_v,
  output logic [1:0] we,
  output logic       newer_o
);
  logic newer_q;
  logic newer_d;
  logic older;
  logic victim;

  always_comb begin
    older   = ~newer_q;
    newer_d = newer_q;
    we      = 2'b00;
    victim  = older;
    if (upd_valid) begin
      if (upd_hit[newer_q]) begin
        newer_d = newer_q;
      end else if (upd_hit[older]) begin
        newer_d = older;
      end else begin
        if (!slot_v[older])        victim = older;
        else if (!slot_v[newer_q]) victim = newer_q;
        else                       victim = older;
        we[victim] = 1'b1;
        newer_d    = victim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) newer_q <= 1'b0;
    else        newer_q <= newer_d;
  end

  assign newer_o = newer_q;
endmodule

// File: rtl/branch_group_cache.sv
module branch_group_cache
  import bgc_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned IW    = 24,
  parameter int unsigned GROUP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_valid,
  input  logic [AW-1:0]       upd_addr,
  input  logic [GROUP*IW-1:0] upd_group,
  input  logic [AW-1:0]       lk_addr,
  output logic                lk_hit,
  output logic [GROUP*IW-1:0] lk_group,
  output logic                lk_rank
);
  localparam int unsigned GW = GROUP * IW;
  localparam int unsigned NS = NUM_SLOTS;

  logic [NS-1:0]         slot_v;
  logic [NS-1:0][AW-1:0] slot_a;
  logic [NS-1:0][GW-1:0] slot_g;
  logic [NS-1:0]         slot_we;
  logic [NS-1:0]         upd_hv;
  logic [NS-1:0]         lk_hv;
  logic                  newer_q;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    bgc_slot #(.AW(AW), .GW(GW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (slot_we[i]),
      .wr_addr (upd_addr),
      .wr_group(upd_group),
      .valid_o (slot_v[i]),
      .addr_o  (slot_a[i]),
      .group_o (slot_g[i])
    );
  end

  bgc_match #(.AW(AW), .NS(NS)) u_upd_match (
    .slot_v (slot_v),
    .slot_a (slot_a),
    .addr   (upd_addr),
    .hit_vec(upd_hv)
  );

  bgc_match #(.AW(AW), .NS(NS)) u_lk_match (
    .slot_v (slot_v),
    .slot_a (slot_a),
    .addr   (lk_addr),
    .hit_vec(lk_hv)
  );

  bgc_recency u_recency (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(upd_valid),
    .upd_hit  (upd_hv),
    .slot_v   (slot_v),
    .we       (slot_we),
    .newer_o  (newer_q)
  );

  rank_e rank_sel;

  always_comb begin
    lk_hit   = 1'b0;
    lk_group = '0;
    rank_sel = RANK_NEW;
    if (lk_hv[newer_q]) begin
      lk_hit   = 1'b1;
      lk_group = slot_g[newer_q];
      rank_sel = RANK_NEW;
    end else if (lk_hv[~newer_q]) begin
      lk_hit   = 1'b1;
      lk_group = slot_g[~newer_q];
      rank_sel = RANK_OLD;
    end
  end

  assign lk_rank = rank_sel;
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int unsigned AW = 12,
  parameter int unsigned GW = 72
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_valid,
  input logic [AW-1:0]       upd_addr,
  input logic                lk_hit,
  input logic [GW-1:0]       lk_group,
  input logic                lk_rank,
  input logic [1:0]          slot_v,
  input logic [1:0][AW-1:0]  slot_a,
  input logic [1:0][GW-1:0]  slot_g,
  input logic                newer
);
  logic older;
  assign older = ~newer;

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (slot_v == 2'b00));

  p_fill_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ((slot_v[0] && slot_a[0] == $past(upd_addr)) ||
                   (slot_v[1] && slot_a[1] == $past(upd_addr))));

  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_v) >= $past($countones(slot_v)));

  p_newer_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && slot_v[newer] && slot_a[newer] == upd_addr)
      |=> ($stable(slot_a) && $stable(slot_g) && $stable(newer)));

  p_older_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && slot_v[older] && slot_a[older] == upd_addr)
      |=> ((newer != $past(newer)) && $stable(slot_a) && $stable(slot_g)));

  p_target_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (slot_v[newer] && slot_a[newer] == $past(upd_addr)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(slot_v) && $stable(slot_a) && $stable(slot_g) && $stable(newer)));

  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_group == '0 && lk_rank == 1'b0));
endmodule

bind branch_group_cache bgc_checker #(.AW(AW), .GW(GW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_valid(upd_valid),
  .upd_addr (upd_addr),
  .lk_hit   (lk_hit),
  .lk_group (lk_group),
  .lk_rank  (lk_rank),
  .slot_v   (slot_v),
  .slot_a   (slot_a),
  .slot_g   (slot_g),
  .newer    (newer_q)
);

// File: tb/test_branch_group_cache.sv
module test_branch_group_cache;
  localparam int AW = 12;
  localparam int IW = 24;
  localparam int GROUP = 3;
  localparam int GW = GROUP * IW;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_addr = '0;
  logic [GW-1:0] upd_group = '0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [GW-1:0] lk_group;
  logic          lk_rank;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  branch_group_cache #(.AW(AW), .IW(IW), .GROUP(GROUP)) i_branch_group_cache (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_group(upd_group), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_group(lk_group), .lk_rank(lk_rank)
  );

  typedef struct {
    logic          hit;
    logic          rank;
    logic [GW-1:0] group;
    string         tag;
  } exp_t;

  exp_t sb[$];
  bit   probe = 1'b0;

  // ranked model: index 0 newer, index 1 older
  logic          m_v [2];
  logic [AW-1:0] m_a [2];
  logic [GW-1:0] m_g [2];

  function automatic logic [GW-1:0] mk_group(input int seed);
    logic [GW-1:0] g;
    for (int k = 0; k < GROUP; k++) g[k*IW +: IW] = IW'(seed * 4099 + k * 257 + 1);
    return g;
  endfunction

  function automatic exp_t model_look(input logic [AW-1:0] a, input string tag);
    exp_t e;
    e.hit = 1'b0; e.rank = 1'b0; e.group = '0; e.tag = tag;
    if (m_v[0] && m_a[0] == a) begin e.hit = 1'b1; e.group = m_g[0]; end
    else if (m_v[1] && m_a[1] == a) begin e.hit = 1'b1; e.rank = 1'b1; e.group = m_g[1]; end
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_v[i] = 1'b0; m_a[i] = '0; m_g[i] = '0; end
  endtask

  task automatic model_update(input logic [AW-1:0] a, input logic [GW-1:0] g);
    logic          tv; logic [AW-1:0] ta; logic [GW-1:0] tg;
    if (m_v[0] && m_a[0] == a) begin
    end else if (m_v[1] && m_a[1] == a) begin
      tv = m_v[0]; ta = m_a[0]; tg = m_g[0];
      m_v[0] = m_v[1]; m_a[0] = m_a[1]; m_g[0] = m_g[1];
      m_v[1] = tv; m_a[1] = ta; m_g[1] = tg;
    end else begin
      m_v[1] = m_v[0]; m_a[1] = m_a[0]; m_g[1] = m_g[0];
      m_v[0] = 1'b1; m_a[0] = a; m_g[0] = g;
    end
  endtask

  // driver: one cycle of optional update plus a checked lookup
  task automatic step(input bit upd, input logic [AW-1:0] ua, input logic [GW-1:0] ug,
                      input logic [AW-1:0] la, input string tag);
    @(negedge clk);
    upd_valid = upd; upd_addr = ua; upd_group = ug; lk_addr = la;
    sb.push_back(model_look(la, tag));
    probe = 1'b1;
    if (upd) model_update(ua, ug);
  endtask

  task automatic look(input logic [AW-1:0] la, input string tag);
    step(1'b0, '0, '0, la, tag);
  endtask

  // monitor: compares a quarter period after the drive, well before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (probe) begin
        exp_t e;
        e = sb.pop_front();
        probe = 1'b0;
        n_checks++;
        if (lk_hit !== e.hit || lk_rank !== e.rank || lk_group !== e.group) begin
          n_fail++;
          $display("FAIL %s addr=%0d: got hit=%0b rank=%0b group=%h, expected hit=%0b rank=%0b group=%h",
                   e.tag, lk_addr, lk_hit, lk_rank, lk_group, e.hit, e.rank, e.group);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [GW-1:0] ga, gb, gc, gx;
    logic [AW-1:0] ra, la;
    int lcg;
    ga = mk_group(15); gb = mk_group(40); gc = mk_group(99); gx = mk_group(7);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look(12'd15, "R1 empty after reset");
    look(12'd15, "R8 miss is zero");
    // same-cycle update and lookup see old contents
    step(1'b1, 12'd15, ga, 12'd15, "R7 pre-update view");
    look(12'd15, "R2 filled entry hits newest");
    #(CLK_P/4);
    n_checks++;
    if (lk_group[0 +: IW] !== ga[0 +: IW] || lk_group[2*IW +: IW] !== ga[2*IW +: IW]) begin
      n_fail++;
      $display("FAIL R9 packing: got %h, expected %h", lk_group, ga);
    end
    step(1'b1, 12'd40, gb, 12'd40, "R7 pre-update second");
    look(12'd40, "R3 second fill newest");
    look(12'd15, "R3 first fill kept older");
    step(1'b1, 12'd40, gx, 12'd40, "R4 hit newest");
    look(12'd40, "R4 group unchanged");
    look(12'd15, "R4 rank unchanged");
    step(1'b1, 12'd15, gx, 12'd15, "R7 swap not yet visible");
    look(12'd15, "R5 swapped to newest");
    look(12'd40, "R5 swapped to older");
    step(1'b1, 12'd99, gc, 12'd99, "R7 replace not yet visible");
    look(12'd99, "R6 new entry newest");
    look(12'd15, "R6 old newest demoted");
    look(12'd40, "R6 replaced entry gone");
    look(12'd123, "R8 unknown address");
    step(1'b0, 12'd40, gb, 12'd99, "R7 no update no change");
    look(12'd99, "R7 still present");

    lcg = 5;
    for (int i = 0; i < 60; i++) begin
      lcg = (lcg * 1103 + 12345) % 65536;
      ra = AW'(1 + (lcg / 7) % 3);
      la = AW'(1 + (lcg / 31) % 3);
      step((lcg % 4) != 0, ra, mk_group(lcg % 500), la, "R6 sequence");
    end
    look(12'd1, "R6 sequence end");

    @(negedge clk);
    upd_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    look(12'd99, "R1 cleared by reset");
    look(12'd1, "R1 cleared by reset second");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule